// File: doc/BRIEF.md
# ADC Result Window Comparator

This block watches conversion results as they leave an ADC and raises an event when a result from a watched input channel meets the selected limit conditions. Each completed conversion arrives as a single-cycle strobe. The strobe carries a 16-bit result, the 5-bit number of the channel it came from, and a flag that says whether that channel produces two's-complement data. The comparison starts on its own whenever a result arrives. No software action is needed for each result.

Software sets the block up through plain configuration pins:

- A 32-bit limit word that holds the high and low limits.
- A 32-bit mask that selects which channels are watched.
- A global enable.
- Five condition-enable bits.

Limits are compared as raw 16-bit values. Software must write them in the same format as the results. When an event occurs, the block sets a sticky status flag, captures the channel number and sends a one-cycle interrupt pulse. The result input is a strobe with no ready signal. The block takes every result in the cycle it is presented, so it never applies back-pressure and a strobe may be high on every cycle.

Top module: `adc_window_cmp`

## Requirements
- R1: A result counts only if `res_valid` is high, `cfg_enable` is high and `cfg_chan_en[res_chan]` is set. A result from a channel whose mask bit is clear never causes an event.
- R2: The high limit is `cfg_limits[31:16]` and the low limit is `cfg_limits[15:0]`.
- R3: Condition bit 0 (in-window) hits when low ≤ result < high. The low bound is inclusive and the high bound is exclusive.
- R4: Condition bit 1 (at or above high) hits when high ≤ result. Condition bit 2 (below high) hits when result < high.
- R5: Condition bit 3 (at or above low) hits when low ≤ result. Condition bit 4 (below low) hits when result < low.
- R6: If `res_signed` is 1, the result and both limits are compared as two's-complement numbers. Otherwise they are compared as unsigned numbers.
- R7: An event is the OR of the hits of all enabled condition bits. If `cfg_cond` is zero, no event occurs.
- R8: On an event, `evt_flag` is 1 and `evt_chan` holds that result's channel from the next cycle on. A later event overwrites `evt_chan` even while the flag is already set.
- R9: `evt_flag` stays set until a cycle with `clr_event` high clears it. If an event occurs in the same cycle as the clear, the event wins.
- R10: `evt_irq` is high for exactly the one cycle after each cycle that holds an event, and is low at all other times.
- R11: When `cfg_enable` is low, no new events occur, and `evt_flag` and `evt_chan` keep their values.
- R12: After reset, `evt_flag`, `evt_chan` and `evt_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| res_valid | input | 1 | A conversion result is present this cycle |
| res_data | input | 16 | Conversion result |
| res_chan | input | 5 | Channel number of the result |
| res_signed | input | 1 | Result is two's complement |
| cfg_limits | input | 32 | High limit [31:16], low limit [15:0] |
| cfg_chan_en | input | 32 | One watch-enable bit per channel |
| cfg_enable | input | 1 | Global comparator enable |
| cfg_cond | input | 5 | Condition enables: in-window, at/above high, below high, at/above low, below low |
| clr_event | input | 1 | Clears the status flag (write-one-to-clear strobe) |
| evt_flag | output | 1 | Sticky event status |
| evt_chan | output | 5 | Channel that caused the latest event |
| evt_irq | output | 1 | One-cycle interrupt pulse |

## Verification
The bench builds the block with its default 16-bit data width and 5-bit channel number. This gives all 32 mask bits and signed limits whose sign bit sits at bit 15. With these values, the exact bound results (low−1, low, high−1, high) are reachable, and so are results that straddle zero, where signed and unsigned order disagree. A random phase also produces back-to-back strobes, events that coincide with a clear, and masked channels across the full channel range.

// File: rtl/adcwc_pkg.sv
package adcwc_pkg;
  localparam int COND_N     = 5;
  localparam int C_INWIN    = 0;
  localparam int C_GE_HIGH  = 1;
  localparam int C_LT_HIGH  = 2;
  localparam int C_GE_LOW   = 3;
  localparam int C_LT_LOW   = 4;
endpackage

// File: rtl/adcwc_limit_cmp.sv
module adcwc_limit_cmp
  import adcwc_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] data,
  input  logic [DATA_W-1:0] lim_hi,
  input  logic [DATA_W-1:0] lim_lo,
  input  logic              is_signed,
  output logic [COND_N-1:0] hits
);
  localparam int EXT_W = DATA_W + 1;

  logic signed [EXT_W-1:0] d_x, hi_x, lo_x;
  logic ge_hi, ge_lo;

  // One extra bit: the sign bit for signed data, a zero for unsigned data.
  always_comb begin
    d_x  = {is_signed & data[DATA_W-1],   data};
    hi_x = {is_signed & lim_hi[DATA_W-1], lim_hi};
    lo_x = {is_signed & lim_lo[DATA_W-1], lim_lo};
    ge_hi = (d_x >= hi_x);
    ge_lo = (d_x >= lo_x);
    hits = '0;
    hits[C_INWIN]   = ge_lo & ~ge_hi;
    hits[C_GE_HIGH] = ge_hi;
    hits[C_LT_HIGH] = ~ge_hi;
    hits[C_GE_LOW]  = ge_lo;
    hits[C_LT_LOW]  = ~ge_lo;
  end
endmodule

// File: rtl/adcwc_chan_gate.sv
module adcwc_chan_gate #(
  parameter int CH_W = 5,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic              valid,
  input  logic              glob_en,
  input  logic [CH_W-1:0]   chan,
  input  logic [NUM_CH-1:0] mask,
  output logic              qualified
);
  logic [NUM_CH-1:0] sel;

  // One-hot decode of the channel number, ANDed with its mask bit.
  for (genvar i = 0; i < NUM_CH; i++) begin : g_dec
    assign sel[i] = (chan == CH_W'(i)) & mask[i];
  end

  assign qualified = valid & glob_en & (|sel);
endmodule

// File: rtl/adcwc_event_reg.sv
module adcwc_event_reg #(
  parameter int CH_W = 5
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            fire,
  input  logic [CH_W-1:0] chan,
  input  logic            clr,
  output logic            flag,
  output logic [CH_W-1:0] chan_q,
  output logic            irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      flag   <= 1'b0;
      chan_q <= '0;
      irq    <= 1'b0;
    end else begin
      irq <= fire;
      if (fire) begin
        flag   <= 1'b1;
        chan_q <= chan;
      end else if (clr) begin
        flag <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/adc_window_cmp.sv
module adc_window_cmp
  import adcwc_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int CH_W   = 5,
  localparam int NUM_CH = 1 << CH_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              res_valid,
  input  logic [DATA_W-1:0] res_data,
  input  logic [CH_W-1:0]   res_chan,
  input  logic              res_signed,
  input  logic [2*DATA_W-1:0] cfg_limits,
  input  logic [NUM_CH-1:0] cfg_chan_en,
  input  logic              cfg_enable,
  input  logic [COND_N-1:0] cfg_cond,
  input  logic              clr_event,
  output logic              evt_flag,
  output logic [CH_W-1:0]   evt_chan,
  output logic              evt_irq
);
  logic [COND_N-1:0] hits;
  logic              qualified;
  logic              fire;

  adcwc_limit_cmp #(.DATA_W(DATA_W)) u_cmp (
    .data      (res_data),
    .lim_hi    (cfg_limits[2*DATA_W-1:DATA_W]),
    .lim_lo    (cfg_limits[DATA_W-1:0]),
    .is_signed (res_signed),
    .hits      (hits)
  );

  adcwc_chan_gate #(.CH_W(CH_W)) u_gate (
    .valid     (res_valid),
    .glob_en   (cfg_enable),
    .chan      (res_chan),
    .mask      (cfg_chan_en),
    .qualified (qualified)
  );

  assign fire = qualified & (|(hits & cfg_cond));

  adcwc_event_reg #(.CH_W(CH_W)) u_evt (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .chan   (res_chan),
    .clr    (clr_event),
    .flag   (evt_flag),
    .chan_q (evt_chan),
    .irq    (evt_irq)
  );
endmodule

// File: rtl/adcwc_checker.sv
module adcwc_checker #(
  parameter int CH_W = 5,
  parameter int COND_N = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              res_valid,
  input logic [CH_W-1:0]   res_chan,
  input logic              cfg_enable,
  input logic [COND_N-1:0] cfg_cond,
  input logic              clr_event,
  input logic              evt_flag,
  input logic [CH_W-1:0]   evt_chan,
  input logic              evt_irq
);
  // R10: an interrupt only follows a presented result
  a_r10_irq_needs_result: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(evt_irq) |-> $past(res_valid));
  // R8: an interrupt always comes with the status flag set
  a_r8_irq_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    evt_irq |-> evt_flag);
  // R8: the captured channel is the one presented the cycle before
  a_r8_chan_capture: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid && cfg_enable |=> !evt_irq || evt_chan == $past(res_chan));
  // R11: with the comparator disabled, nothing fires
  a_r11_disabled_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> !evt_irq);
  // R11: with the comparator disabled and no clear, the status holds
  a_r11_status_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable && !clr_event |=> $stable(evt_flag) && $stable(evt_chan));
  // R7: no enabled condition, no event
  a_r7_no_cond: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_cond == '0 |=> !evt_irq);
  // R9: the flag is sticky until a clear
  a_r9_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    evt_flag && !clr_event |=> evt_flag);
endmodule

bind adc_window_cmp adcwc_checker #(.CH_W(CH_W), .COND_N(adcwc_pkg::COND_N)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .res_valid  (res_valid),
  .res_chan   (res_chan),
  .cfg_enable (cfg_enable),
  .cfg_cond   (cfg_cond),
  .clr_event  (clr_event),
  .evt_flag   (evt_flag),
  .evt_chan   (evt_chan),
  .evt_irq    (evt_irq)
);

// File: tb/adc_window_cmp_bench.sv
module adc_window_cmp_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        res_valid = 1'b0;
  logic [15:0] res_data = '0;
  logic [4:0]  res_chan = '0;
  logic        res_signed = 1'b0;
  logic [31:0] cfg_limits = '0;
  logic [31:0] cfg_chan_en = '0;
  logic        cfg_enable = 1'b0;
  logic [4:0]  cfg_cond = '0;
  logic        clr_event = 1'b0;
  logic        evt_flag;
  logic [4:0]  evt_chan;
  logic        evt_irq;

  int checks = 0, fails = 0;
  string tag = "R12";
  bit done = 0;

  // model state
  bit m_flag = 0, m_irq = 0;
  int m_chan = 0;

  always #2.5 clk = ~clk;

  adc_window_cmp u_adc_window_cmp (.*);

  function automatic int as_num(input int v, input bit sgn);
    return (sgn && v >= 32768) ? v - 65536 : v;
  endfunction

  // Hit of one result against the limits and the enabled conditions.
  function automatic bit model_hit();
    int d, hi, lo;
    bit h;
    d  = as_num(int'(res_data), res_signed);
    hi = as_num(int'(cfg_limits[31:16]), res_signed);
    lo = as_num(int'(cfg_limits[15:0]), res_signed);
    h = 0;
    if (cfg_cond[0] && lo <= d && d < hi) h = 1;
    if (cfg_cond[1] && hi <= d) h = 1;
    if (cfg_cond[2] && d < hi) h = 1;
    if (cfg_cond[3] && lo <= d) h = 1;
    if (cfg_cond[4] && d < lo) h = 1;
    return h && res_valid && cfg_enable && cfg_chan_en[res_chan];
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_flag = 0; m_irq = 0; m_chan = 0;
    end else begin
      bit f;
      f = model_hit();
      m_irq = f;
      if (f) begin m_flag = 1; m_chan = int'(res_chan); end
      else if (clr_event) m_flag = 0;
    end
  end

  // Compare every cycle, away from the active edge.
  always @(negedge clk) begin
    checks++;
    if (evt_flag !== m_flag || evt_irq !== m_irq || int'(evt_chan) !== m_chan) begin
      fails++;
      $display("FAIL %s: flag/irq/chan actual %0b/%0b/%0d expected %0b/%0b/%0d",
               tag, evt_flag, evt_irq, evt_chan, m_flag, m_irq, m_chan);
    end
  end

  task automatic send(input logic [15:0] d, input logic [4:0] ch, input bit sgn);
    @(negedge clk);
    res_valid = 1; res_data = d; res_chan = ch; res_signed = sgn;
    @(negedge clk);
    res_valid = 0;
  endtask

  task automatic clear();
    @(negedge clk); clr_event = 1;
    @(negedge clk); clr_event = 0;
  endtask

  // Exercise one condition around both bounds.
  task automatic sweep(input string t, input logic [4:0] cond);
    tag = t; cfg_cond = cond;
    cfg_limits = {16'h0C00, 16'h0500};
    foreach (bounds[i]) begin
      send(bounds[i], 5'd8, 0);
      clear();
    end
  endtask

  logic [15:0] bounds [6] = '{16'h04FF, 16'h0500, 16'h0501, 16'h0BFF, 16'h0C00, 16'hFFFF};

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    cfg_enable = 1; cfg_chan_en = 32'h0000_0100;
    sweep("R3", 5'b00001);
    sweep("R4", 5'b00010);
    sweep("R4", 5'b00100);
    sweep("R5", 5'b01000);
    sweep("R5", 5'b10000);
    sweep("R2", 5'b00011);
    sweep("R7", 5'b00000);
    tag = "R7"; cfg_cond = 5'b10010;
    send(16'h0100, 5'd8, 0); send(16'h0D00, 5'd8, 0); clear();
    // signed window -256..255
    tag = "R6"; cfg_cond = 5'b00001; cfg_limits = {16'h0100, 16'hFF00};
    send(16'hFFF0, 5'd8, 1); clear();
    send(16'hFFF0, 5'd8, 0); clear();
    send(16'hFEFF, 5'd8, 1); clear();
    tag = "R1"; cfg_chan_en = 32'h8000_0001;
    send(16'h0000, 5'd8, 1); send(16'h0000, 5'd31, 1);
    tag = "R8"; send(16'h0000, 5'd0, 1);
    tag = "R11"; cfg_enable = 0;
    send(16'h0000, 5'd31, 1); repeat (3) @(negedge clk);
    cfg_enable = 1;
    tag = "R9"; clear();
    @(negedge clk);
    res_valid = 1; res_data = 0; res_chan = 5'd31; res_signed = 1; clr_event = 1;
    @(negedge clk); res_valid = 0; clr_event = 0;
    repeat (2) @(negedge clk);
    tag = "R10";
    for (int i = 0; i < 400; i++) begin
      @(negedge clk);
      res_valid  = $urandom_range(0, 1);
      res_data   = 16'($urandom);
      res_chan   = 5'($urandom);
      res_signed = $urandom_range(0, 1);
      clr_event  = ($urandom_range(0, 3) == 0);
      cfg_enable = ($urandom_range(0, 7) != 0);
      cfg_cond   = 5'($urandom);
      if (i % 50 == 0) begin
        cfg_chan_en = $urandom;
        cfg_limits  = $urandom;
      end
    end
    @(negedge clk); res_valid = 0; clr_event = 0;
    repeat (3) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule